// File: doc/BRIEF.md
# DS3 Parity Error Monitor

This block sits on the receive side of a DS3 path and counts P-bit parity violations, one possible event per M-frame. A framer in front of it supplies a strobe at the end of each M-frame, together with a flag that says whether the received P-bits disagreed with the parity computed over the previous frame. The block keeps a 16-bit event count. A host reads that count over a synchronous byte bus as two read-only bytes, and each reading clears the count.

The block also has a parity-based loss-of-frame detector. A sliding history of the last five M-frame parity results raises an out-of-frame flag when two or more of those frames were errored. The flag is active only while the parity-framing option is enabled. It stays set until the framer reports that reframing has finished.

Top module: `ds3_parity_mon`

## Requirements
- R1: After reset the event count, the captured snapshot, `busRdata` and `oof` are all zero.
- R2: A cycle with `frameEnd` and `parityErr` both high adds one to the event count. `parityErr` without `frameEnd` has no effect.
- R3: A read strobe at address 0x54 returns count bits 15:8 on `busRdata` in the next cycle. The same read captures the full 16-bit count into a snapshot and clears the live count.
- R4: A read strobe at address 0x55 returns bits 7:0 of the snapshot taken at the last 0x54 read in the next cycle. Before any such read it returns zero.
- R5: An error event in the same cycle as a 0x54 read leaves the live count at 1, not 0.
- R6: The count saturates at 0xFFFF and does not wrap.
- R7: `busRdata` is zero in every cycle that does not follow a read strobe at 0x54 or 0x55, including reads of any other address.
- R8: With `parityFrameEn` high, the history shifts in `parityErr` on each `frameEnd`. `oof` rises one cycle after the history of the last five frames holds two or more errors, which is two clock edges after the edge that samples the second errored `frameEnd`.
- R9: `oof` stays high until `reframeDone`. `reframeDone` clears `oof` and the frame history, and it takes priority over a `frameEnd` in the same cycle.
- R10: With `parityFrameEn` low, `oof` is held low and error counting continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| frameEnd | input | 1 | One-cycle pulse at the end of each M-frame |
| parityErr | input | 1 | P-bit parity mismatch for the frame closed by `frameEnd` |
| reframeDone | input | 1 | Pulse from the framer once reframing has finished |
| parityFrameEn | input | 1 | Enables the parity-based out-of-frame detector |
| busAddr | input | 8 | Host register address |
| busRd | input | 1 | Host read strobe |
| busRdata | output | 8 | Read data, valid the cycle after the strobe |
| oof | output | 1 | Out-of-frame from the parity history |

## Verification
The assertions assume that `frameEnd` is only meaningful as a one-cycle event and that `parityErr` is looked at only when `frameEnd` is high. They also assume that a host read is a single-cycle strobe whose address is stable in that cycle. The stimulus drives all inputs at the falling edge, so each value is held for exactly one rising edge. Random phases mix frame strobes, errors, rare reframe pulses, option toggles and reads at mapped and unmapped addresses, so they include same-cycle events and reads. The directed cases cover saturation, the coincident event and clear, and the reframe-over-frame priority.

// File: rtl/pmon_pkg.sv
package pmon_pkg;
  // Strobes from control to datapath, one cycle each
  typedef struct packed {
    logic capHi;    // high-byte read: snapshot and clear
    logic rdHi;     // return high byte next cycle
    logic rdLo;     // return snapshot low byte next cycle
    logic errEvt;   // an errored M-frame closed this cycle
    logic winShift; // push one frame result into the history
    logic winBit;   // the result being pushed
    logic winClr;   // wipe the history and the flag
  } pmonStrb_t;
endpackage

// File: rtl/pmon_ctrl.sv
module pmon_ctrl
  import pmon_pkg::*;
#(
  parameter int AW = 8,
  parameter logic [AW-1:0] ADDR_HI = 8'h54,
  parameter logic [AW-1:0] ADDR_LO = 8'h55
) (
  input  logic          frameEnd,
  input  logic          parityErr,
  input  logic          reframeDone,
  input  logic [AW-1:0] busAddr,
  input  logic          busRd,
  output pmonStrb_t     strb
);
  logic hitHi, hitLo;

  always_comb begin
    hitHi         = busRd && (busAddr == ADDR_HI);
    hitLo         = busRd && (busAddr == ADDR_LO);
    strb.capHi    = hitHi;
    strb.rdHi     = hitHi;
    strb.rdLo     = hitLo;
    strb.errEvt   = frameEnd && parityErr;
    strb.winClr   = reframeDone;
    strb.winShift = frameEnd && !reframeDone;
    strb.winBit   = parityErr;
  end
endmodule

// File: rtl/pmon_dpath.sv
module pmon_dpath
  import pmon_pkg::*;
#(
  parameter int DW         = 8,
  parameter int WIN_LEN    = 5,
  parameter int WIN_THRESH = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          parityFrameEn,
  input  pmonStrb_t     strb,
  output logic [DW-1:0] busRdata,
  output logic          oof
);
  localparam int CNT_W = 2 * DW;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam int PCW = $clog2(WIN_LEN + 1);
  localparam logic [PCW-1:0] THR = PCW'(WIN_THRESH);

  logic [CNT_W-1:0]   cnt, shadow;
  logic [WIN_LEN-1:0] win;
  logic [PCW-1:0]     winPop;

  // event counter with snapshot-and-clear
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt    <= '0;
      shadow <= '0;
    end else begin
      if (strb.capHi) begin
        shadow <= cnt;
        cnt    <= {{(CNT_W-1){1'b0}}, strb.errEvt};
      end else if (strb.errEvt && cnt != CNT_MAX) begin
        cnt <= cnt + CNT_W'(1);
      end
    end
  end

  // registered read data
  always_ff @(posedge clk) begin
    if (!rstN) busRdata <= '0;
    else if (strb.rdHi) busRdata <= cnt[CNT_W-1 -: DW];
    else if (strb.rdLo) busRdata <= shadow[DW-1:0];
    else busRdata <= '0;
  end

  // frame history
  generate
    if (WIN_LEN > 1) begin : g_shift
      always_ff @(posedge clk) begin
        if (!rstN || strb.winClr) win <= '0;
        else if (strb.winShift) win <= {win[WIN_LEN-2:0], strb.winBit};
      end
    end else begin : g_single
      always_ff @(posedge clk) begin
        if (!rstN || strb.winClr) win <= '0;
        else if (strb.winShift) win <= strb.winBit;
      end
    end
  endgenerate

  always_comb begin
    winPop = '0;
    for (int i = 0; i < WIN_LEN; i++) winPop = winPop + PCW'(win[i]);
  end

  // sticky out-of-frame flag
  always_ff @(posedge clk) begin
    if (!rstN) oof <= 1'b0;
    else oof <= parityFrameEn && !strb.winClr && (oof || winPop >= THR);
  end

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (strb.errEvt && !strb.capHi && cnt != CNT_MAX) |=> cnt == $past(cnt) + CNT_W'(1)); // R2
  AST_SNAPSHOT: assert property (@(posedge clk) disable iff (!rstN)
    strb.capHi |=> shadow == $past(cnt)); // R3
  AST_CLR_KEEPS_EVENT: assert property (@(posedge clk) disable iff (!rstN)
    (strb.capHi && strb.errEvt) |=> cnt == CNT_W'(1)); // R5
  AST_CLR_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    (strb.capHi && !strb.errEvt) |=> cnt == '0); // R3
  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (cnt == CNT_MAX && !strb.capHi) |=> cnt == CNT_MAX); // R6
  AST_IDLE_BUS: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.rdHi || strb.rdLo) |=> busRdata == '0); // R7
  AST_OOF_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (oof && parityFrameEn && !strb.winClr) |=> oof); // R9
  AST_REFRAME_CLR: assert property (@(posedge clk) disable iff (!rstN)
    strb.winClr |=> (!oof && win == '0)); // R9
  AST_OOF_OFF: assert property (@(posedge clk) disable iff (!rstN)
    !parityFrameEn |=> !oof); // R10
endmodule

// File: rtl/ds3_parity_mon.sv
module ds3_parity_mon
  import pmon_pkg::*;
#(
  parameter int DW         = 8,
  parameter int AW         = 8,
  parameter int WIN_LEN    = 5,
  parameter int WIN_THRESH = 2,
  parameter logic [AW-1:0] ADDR_HI = 8'h54,
  parameter logic [AW-1:0] ADDR_LO = 8'h55
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          frameEnd,
  input  logic          parityErr,
  input  logic          reframeDone,
  input  logic          parityFrameEn,
  input  logic [AW-1:0] busAddr,
  input  logic          busRd,
  output logic [DW-1:0] busRdata,
  output logic          oof
);
  pmonStrb_t strb;

  pmon_ctrl #(.AW(AW), .ADDR_HI(ADDR_HI), .ADDR_LO(ADDR_LO)) u_ctrl (
    .frameEnd(frameEnd), .parityErr(parityErr), .reframeDone(reframeDone),
    .busAddr(busAddr), .busRd(busRd), .strb(strb)
  );

  pmon_dpath #(.DW(DW), .WIN_LEN(WIN_LEN), .WIN_THRESH(WIN_THRESH)) u_dpath (
    .clk(clk), .rstN(rstN), .parityFrameEn(parityFrameEn), .strb(strb),
    .busRdata(busRdata), .oof(oof)
  );

  AST_RESET_OOF: assert property (@(posedge clk) !rstN |=> !oof); // R1
endmodule

// File: tb/ds3_parity_mon_bench.sv
module ds3_parity_mon_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic frameEnd = 0, parityErr = 0, reframeDone = 0, parityFrameEn = 1;
  logic [7:0] busAddr = 0;
  logic busRd = 0;
  logic [7:0] busRdata;
  logic oof;

  int nTests = 0, nFail = 0;
  bit done = 0;

  // reference model state
  logic [15:0] mCnt = 0, mShadow = 0;
  logic [4:0]  mWin = 0;
  logic        mOof = 0;
  logic [7:0]  mRdata = 0;

  always #4 clk = ~clk;

  ds3_parity_mon u_ds3_parity_mon (
    .clk(clk), .rstN(rstN), .frameEnd(frameEnd), .parityErr(parityErr),
    .reframeDone(reframeDone), .parityFrameEn(parityFrameEn),
    .busAddr(busAddr), .busRd(busRd), .busRdata(busRdata), .oof(oof)
  );

  function automatic int f_pop(logic [4:0] w);
    int n = 0;
    for (int i = 0; i < 5; i++) n += int'(w[i]);
    return n;
  endfunction

  function automatic logic [7:0] f_readVal(logic rd, logic [7:0] a, logic [15:0] c, logic [15:0] s);
    if (!rd) return 8'h00;
    if (a == 8'h54) return c[15:8];
    if (a == 8'h55) return s[7:0];
    return 8'h00;
  endfunction

  task automatic check(string tag, logic [15:0] got, logic [15:0] exp);
    nTests++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  // one cycle: drive at negedge, model at posedge, compare at next negedge
  task automatic step(logic fe, logic pe, logic rf, logic rd, logic [7:0] a, string tag);
    logic [15:0] nCnt;
    frameEnd = fe; parityErr = pe; reframeDone = rf; busRd = rd; busAddr = a;
    @(posedge clk);
    nCnt = mCnt;
    mRdata = f_readVal(rd, a, mCnt, mShadow);
    if (rd && a == 8'h54) begin
      mShadow = mCnt;
      nCnt = (fe && pe) ? 16'd1 : 16'd0;
    end else if (fe && pe && mCnt != 16'hFFFF) nCnt = mCnt + 16'd1;
    mOof = parityFrameEn && !rf && (mOof || f_pop(mWin) >= 2);
    if (rf) mWin = 0;
    else if (fe) mWin = {mWin[3:0], pe};
    mCnt = nCnt;
    @(negedge clk);
    check({tag, " rdata"}, {8'h0, busRdata}, {8'h0, mRdata});
    check({tag, " oof"}, {15'h0, oof}, {15'h0, mOof});
  endtask

  task automatic rdReg(logic [7:0] a, logic [7:0] exp, string tag);
    step(0, 0, 0, 1, a, tag);
    check({tag, " direct"}, {8'h0, busRdata}, {8'h0, exp});
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      nTests++; nFail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7341));
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    check("R1 rdata", {8'h0, busRdata}, 16'h0);
    check("R1 oof", {15'h0, oof}, 16'h0);
    rdReg(8'h54, 8'h00, "R1");
    rdReg(8'h55, 8'h00, "R4");

    // R2 counting, parityErr without frameEnd ignored
    repeat (3) step(1, 1, 0, 0, 0, "R2");
    repeat (2) step(0, 1, 0, 0, 0, "R2");
    step(1, 0, 0, 0, 0, "R2");
    rdReg(8'h54, 8'h00, "R3");
    rdReg(8'h55, 8'h03, "R2");
    rdReg(8'h54, 8'h00, "R3");
    rdReg(8'h55, 8'h00, "R3");
    step(0, 0, 1, 0, 0, "R9");
    check("R9 cleared", {15'h0, oof}, 16'h0);

    // R8 two errored frames within five
    step(1, 1, 0, 0, 0, "R8");
    step(0, 0, 0, 0, 0, "R8");
    check("R8 single", {15'h0, oof}, 16'h0);
    step(1, 0, 0, 0, 0, "R8");
    step(1, 0, 0, 0, 0, "R8");
    step(1, 1, 0, 0, 0, "R8");
    check("R8 not yet", {15'h0, oof}, 16'h0);
    step(0, 0, 0, 0, 0, "R8");
    check("R8 raised", {15'h0, oof}, 16'h1);
    // R9 sticky, reframe wins over frame strobe
    repeat (6) step(1, 0, 0, 0, 0, "R9");
    check("R9 sticky", {15'h0, oof}, 16'h1);
    step(1, 1, 1, 0, 0, "R9");
    check("R9 reframe", {15'h0, oof}, 16'h0);
    step(1, 1, 0, 0, 0, "R9");
    repeat (2) step(0, 0, 0, 0, 0, "R9");
    check("R9 history wiped", {15'h0, oof}, 16'h0);
    // R8 errors six frames apart do not trip
    repeat (4) step(1, 0, 0, 0, 0, "R8");
    step(1, 1, 0, 0, 0, "R8");
    repeat (2) step(0, 0, 0, 0, 0, "R8");
    check("R8 spread", {15'h0, oof}, 16'h0);
    step(0, 0, 1, 0, 0, "R9");

    // R5 coincident event and clearing read
    rdReg(8'h54, 8'h00, "R3");
    repeat (2) step(1, 1, 0, 0, 0, "R5");
    step(1, 1, 0, 1, 8'h54, "R5");
    check("R5 hi", {8'h0, busRdata}, 16'h0);
    rdReg(8'h55, 8'h02, "R5");
    rdReg(8'h54, 8'h00, "R5");
    rdReg(8'h55, 8'h01, "R5");

    // R7 unmapped and idle
    rdReg(8'h00, 8'h00, "R7");
    rdReg(8'h56, 8'h00, "R7");
    rdReg(8'hFF, 8'h00, "R7");
    step(0, 0, 0, 0, 8'h54, "R7");
    check("R7 idle", {8'h0, busRdata}, 16'h0);

    // R10 detector off, counting continues
    parityFrameEn = 0;
    step(0, 0, 1, 0, 0, "R10");
    rdReg(8'h54, 8'h00, "R10");
    repeat (3) step(1, 1, 0, 0, 0, "R10");
    repeat (2) step(0, 0, 0, 0, 0, "R10");
    check("R10 oof", {15'h0, oof}, 16'h0);
    rdReg(8'h54, 8'h00, "R10");
    rdReg(8'h55, 8'h03, "R10");
    parityFrameEn = 1;
    step(0, 0, 1, 0, 0, "R9");

    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [7:0] a;
      logic rd;
      if (($urandom % 97) == 0) parityFrameEn = ~parityFrameEn;
      case ($urandom % 4)
        0: a = 8'h54;
        1: a = 8'h55;
        2: a = 8'(($urandom % 256));
        default: a = 8'h54;
      endcase
      rd = (($urandom % 8) == 0);
      step(($urandom % 4) == 0, ($urandom % 5) == 0, ($urandom % 60) == 0,
           rd, a, "R3/R4/R8");
    end
    parityFrameEn = 1;

    // R6 saturation
    rdReg(8'h54, mCnt[15:8], "R6");
    for (int i = 0; i < 65540; i++) step(1, 1, 0, 0, 0, "R6");
    rdReg(8'h54, 8'hFF, "R6");
    rdReg(8'h55, 8'hFF, "R6");
    rdReg(8'h54, 8'h00, "R6");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule